// File: doc/BRIEF.md
# Instruction Fetch Predecoder

This block sits at the front of a small 64-bit processor's fetch stage. It receives the current program-counter value, a ten-byte window of instruction memory starting at that address, and a flag that instruction memory could not supply the bytes. From these it works out what the instruction is and how long it is. It outputs the opcode and function nibbles, the two register specifiers, the optional 64-bit constant, the address of the following instruction, a legality flag and a fetch status code.

An instruction occupies 1, 2, 9 or 10 bytes. The length depends on two things: whether the opcode carries a register-specifier byte, and whether it carries an eight-byte constant. All outputs are combinational from the inputs. The pipeline register that holds the PC belongs to the surrounding design.

Top module: `instr_predecode`

## Requirements
- R1: `opcode` is the upper nibble and `func` the lower nibble of window byte 0. When `imem_err` is high, `opcode` is forced to 1 (no-op) and `func` to 0.
- R2: Opcodes 2, 3, 4, 5, 6, 0xA, 0xB and 0xC carry a register byte at window byte 1. For these, `reg_a` is that byte's upper nibble and `reg_b` its lower nibble. For every other opcode, both specifiers read 0xF (no register).
- R3: Opcodes 7 and 8 take their constant from window bytes 1..8. Opcodes 3, 4, 5 and 0xC take it from bytes 2..9. In both cases the lowest-addressed byte is the least significant. Every other opcode yields a constant of zero.
- R4: `next_pc` is `pc` plus the instruction length, wrapping modulo 2^64. The length is 10 for opcodes 3, 4, 5 and 0xC; 9 for 7 and 8; 2 for 2, 6, 0xA and 0xB; and 1 otherwise. "Otherwise" covers 0, 1, 9, opcodes above 0xC, and a memory error.
- R5: `instr_ok` is high exactly when the effective opcode (after R1's substitution) is at most 0xC.
- R6: `status` is 2 when `imem_err` is high. Otherwise it is 3 for an illegal opcode, 1 for opcode 0 (halt), and 0 in all other cases. Earlier conditions take priority.
- R7: During a memory error, the window contents have no effect. Both specifiers are 0xF, the constant is 0 and `next_pc` is `pc`+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 64 | Address of the instruction being fetched |
| win | input | 80 | Instruction bytes; byte k sits at bits 8k+7:8k |
| imem_err | input | 1 | Instruction memory could not supply the window |
| opcode | output | 4 | Effective opcode nibble |
| func | output | 4 | Effective function nibble |
| reg_a | output | 4 | First register specifier, 0xF when absent |
| reg_b | output | 4 | Second register specifier, 0xF when absent |
| konst | output | 64 | Little-endian constant, 0 when absent |
| next_pc | output | 64 | Fall-through address |
| instr_ok | output | 1 | Effective opcode is legal |
| status | output | 2 | 0 ok, 1 halt, 2 address error, 3 illegal instruction |

## Verification
On every input change, the assertions check several relationships among the outputs. The length step must be one of the four legal sizes. Short forms must report no registers or no constant, as appropriate. A memory error must force the no-op substitution and the address-error status. The legality flag and the illegal status must agree.

Some behaviours can only be shown by the bench's sweeps, which cover every opcode, both error states, and PC values next to the wrap point. These include which window bytes feed the constant, their byte order, the exact length chosen for each opcode, and the correct wrap of `next_pc`.

// File: rtl/predecode_pkg.sv
package predecode_pkg;

    localparam int unsigned NIB_W = 4;

    typedef enum logic [NIB_W-1:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_MOVRR = 4'h2,
        OP_MOVIR = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB,
        OP_ADDI  = 4'hC
    } op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_HALT = 2'd1,
        ST_ADDR = 2'd2,
        ST_ILL  = 2'd3
    } fetch_st_e;

    localparam logic [NIB_W-1:0] REG_NONE = 4'hF;
    localparam logic [NIB_W-1:0] OP_LAST  = 4'hC;

    typedef struct packed {
        logic [NIB_W-1:0] op;
        logic [NIB_W-1:0] fn;
        logic             has_regs;
        logic             has_const;
        logic             legal;
    } op_info_t;

    function automatic logic op_has_regs(input logic [NIB_W-1:0] op);
        case (op)
            OP_MOVRR, OP_MOVIR, OP_STORE, OP_LOAD,
            OP_ALU, OP_PUSH, OP_POP, OP_ADDI: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    function automatic logic op_has_const(input logic [NIB_W-1:0] op);
        case (op)
            OP_MOVIR, OP_STORE, OP_LOAD,
            OP_JUMP, OP_CALL, OP_ADDI: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pd_classify.sv
module pd_classify
    import predecode_pkg::*;
(
    input  logic [7:0] first_byte,
    input  logic       mem_err,
    output op_info_t   info
);
    always_comb begin
        if (mem_err) begin
            info.op = OP_NOP;
            info.fn = '0;
        end else begin
            info.op = first_byte[7:4];
            info.fn = first_byte[3:0];
        end
        info.has_regs  = op_has_regs(info.op);
        info.has_const = op_has_const(info.op);
        info.legal     = (info.op <= OP_LAST);
    end
endmodule

// File: rtl/pd_fields.sv
module pd_fields
    import predecode_pkg::*;
#(
    parameter int unsigned WORD_W = 64,
    localparam int unsigned CBYTES = WORD_W / 8,
    localparam int unsigned WBYTES = CBYTES + 2
) (
    input  logic [8*WBYTES-1:0] win,
    input  op_info_t            info,
    output logic [NIB_W-1:0]    reg_a,
    output logic [NIB_W-1:0]    reg_b,
    output logic [WORD_W-1:0]   konst
);
    logic [WORD_W-1:0] near_word;
    logic [WORD_W-1:0] far_word;

    for (genvar b = 0; b < CBYTES; b++) begin : g_cbyte
        assign near_word[8*b +: 8] = win[8*(b+1) +: 8];
        assign far_word[8*b +: 8]  = win[8*(b+2) +: 8];
    end

    always_comb begin
        reg_a = REG_NONE;
        reg_b = REG_NONE;
        if (info.has_regs) begin
            reg_a = win[15:12];
            reg_b = win[11:8];
        end
        if (!info.has_const)     konst = '0;
        else if (info.has_regs)  konst = far_word;
        else                     konst = near_word;
    end
endmodule

// File: rtl/pd_nextpc.sv
module pd_nextpc
    import predecode_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned WORD_W = 64,
    localparam int unsigned CBYTES = WORD_W / 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  op_info_t          info,
    output logic [ADDR_W-1:0] next_pc,
    output fetch_st_e         status,
    input  logic              mem_err
);
    logic [ADDR_W-1:0] step;

    always_comb begin
        step = ADDR_W'(1);
        if (info.has_regs)  step = step + ADDR_W'(1);
        if (info.has_const) step = step + ADDR_W'(CBYTES);
        next_pc = pc + step;

        if (mem_err)              status = ST_ADDR;
        else if (!info.legal)     status = ST_ILL;
        else if (info.op == OP_HALT) status = ST_HALT;
        else                      status = ST_OK;
    end
endmodule

// File: rtl/instr_predecode.sv
module instr_predecode
    import predecode_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned WORD_W = 64,
    localparam int unsigned WBYTES = WORD_W / 8 + 2
) (
    input  logic [ADDR_W-1:0]   pc,
    input  logic [8*WBYTES-1:0] win,
    input  logic                imem_err,
    output logic [3:0]          opcode,
    output logic [3:0]          func,
    output logic [3:0]          reg_a,
    output logic [3:0]          reg_b,
    output logic [WORD_W-1:0]   konst,
    output logic [ADDR_W-1:0]   next_pc,
    output logic                instr_ok,
    output logic [1:0]          status
);
    op_info_t  info;
    fetch_st_e st;

    pd_classify u_cls (
        .first_byte (win[7:0]),
        .mem_err    (imem_err),
        .info       (info)
    );

    pd_fields #(.WORD_W(WORD_W)) u_fld (
        .win   (win),
        .info  (info),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .konst (konst)
    );

    pd_nextpc #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_npc (
        .pc      (pc),
        .info    (info),
        .next_pc (next_pc),
        .status  (st),
        .mem_err (imem_err)
    );

    assign opcode   = info.op;
    assign func     = info.fn;
    assign instr_ok = info.legal;
    assign status   = st;
endmodule

// File: rtl/predecode_checker.sv
module predecode_checker #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned WORD_W = 64
) (
    input logic [ADDR_W-1:0] pc,
    input logic              imem_err,
    input logic [3:0]        opcode,
    input logic [3:0]        func,
    input logic [3:0]        reg_a,
    input logic [3:0]        reg_b,
    input logic [WORD_W-1:0] konst,
    input logic [ADDR_W-1:0] next_pc,
    input logic              instr_ok,
    input logic [1:0]        status
);
    logic [ADDR_W-1:0] step;
    assign step = next_pc - pc;

    always_comb begin
        a_r4_step_legal: assert (step == 1 || step == 2 || step == 9 || step == 10);
        if (step == 1 || step == 9) begin
            a_r2_no_regs: assert (reg_a == 4'hF && reg_b == 4'hF);
        end
        if (step == 1 || step == 2) begin
            a_r3_no_const: assert (konst == '0);
        end
        if (imem_err) begin
            a_r1_err_nop: assert (opcode == 4'h1 && func == 4'h0);
            a_r6_err_status: assert (status == 2'd2);
            a_r7_err_len: assert (step == 1);
        end else begin
            a_r5_ok_vs_status: assert (instr_ok == (status != 2'd3));
        end
    end
endmodule

bind instr_predecode predecode_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .pc       (pc),
    .imem_err (imem_err),
    .opcode   (opcode),
    .func     (func),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .konst    (konst),
    .next_pc  (next_pc),
    .instr_ok (instr_ok),
    .status   (status)
);

// File: tb/sim_instr_predecode.sv
module sim_instr_predecode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pc_d = '0;
    logic [63:0] pc_q;
    logic [79:0] win = '0;
    logic        imem_err = 1'b0;
    logic [3:0]  opcode, func, reg_a, reg_b;
    logic [63:0] konst, next_pc;
    logic        instr_ok;
    logic [1:0]  status;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    instr_predecode u0 (
        .pc(pc_q), .win(win), .imem_err(imem_err),
        .opcode(opcode), .func(func), .reg_a(reg_a), .reg_b(reg_b),
        .konst(konst), .next_pc(next_pc), .instr_ok(instr_ok), .status(status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [63:0] p, input logic [79:0] w, input logic e);
        logic [3:0]  op, fn, ea, eb;
        logic [63:0] ek, elen;
        logic [1:0]  est;
        logic        regs, cst;
        @(negedge clk);
        pc_d = p; win = w; imem_err = e;
        @(posedge clk);
        #1;
        op = e ? 4'h1 : w[7:4];
        fn = e ? 4'h0 : w[3:0];
        regs = (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB, 4'hC});
        cst  = (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8, 4'hC});
        ea = regs ? w[15:12] : 4'hF;
        eb = regs ? w[11:8]  : 4'hF;
        ek = '0;
        if (cst) begin
            for (int k = 0; k < 8; k++)
                ek = ek + (64'(w[8*(k + (regs ? 2 : 1)) +: 8]) << (8*k));
        end
        elen = 64'd1 + (regs ? 64'd1 : 64'd0) + (cst ? 64'd8 : 64'd0);
        est = e ? 2'd2 : (op > 4'hC) ? 2'd3 : (op == 4'h0) ? 2'd1 : 2'd0;
        chk(e ? "R1/R7 opcode" : "R1 opcode", 64'(opcode), 64'(op));
        chk("R1 func", 64'(func), 64'(fn));
        chk(e ? "R7 reg_a" : "R2 reg_a", 64'(reg_a), 64'(ea));
        chk(e ? "R7 reg_b" : "R2 reg_b", 64'(reg_b), 64'(eb));
        chk(e ? "R7 konst" : "R3 konst", konst, ek);
        chk(e ? "R7 next_pc" : "R4 next_pc", next_pc, p + elen);
        chk("R5 instr_ok", 64'(instr_ok), 64'(op <= 4'hC));
        chk("R6 status", 64'(status), 64'(est));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R6 reset status halt", 64'(status), 64'd1);
        chk("R4 reset next_pc", next_pc, 64'd1);
        @(negedge clk);
        rst = 1'b0;
        for (int op = 0; op < 16; op++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [79:0] w;
                    logic [63:0] p;
                    for (int k = 1; k < 10; k++)
                        w[8*k +: 8] = 8'((k * 37 + s * 91 + op * 13 + 5) & 8'hFF);
                    w[7:0] = {4'(op), 4'((s * 5 + op) & 15)};
                    case (s)
                        0: p = 64'h0;
                        1: p = 64'h100;
                        2: p = 64'hFFFF_FFFF_FFFF_FFF8;
                        default: p = 64'h0123_4567_89AB_CDE0;
                    endcase
                    run_case(p, w, e[0]);
                end
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule